// File: doc/BRIEF.md
# Prioritized Interrupt Vector Address Generator

This block turns a set of per-input conversion-ready flags into an interrupt vector address. The flags arrive as status words, each WORD_W bits wide and two by default, giving one combined index space of 64 inputs. The lowest-numbered flag that is set wins. Its index is shifted left by a programmable amount of 0 to 7 positions and added, modulo 2^32, to a base value that software writes.

Software reaches the block through a small register bus. A read of the base register does not return the stored base; it returns the computed vector address. An interrupt handler can therefore dispatch with one load. A second register holds the shift amount. Reads are registered: the answer appears one cycle after the request, along with a valid strobe. The value reflects the flags and register state present at the clock edge that takes the request.

Top module: `vg_vecaddr_top`

## Requirements
- R1: After reset the stored base and shift are both 0, so a read of offset 0 with no flags set returns 0 and a read of offset 1 returns 0.
- R2: A write to offset 0 stores all 32 bits of the write data as the base; with no flag set, a read of offset 0 returns that base unchanged.
- R3: When several flags are set, the one with the smallest index is used, and flag 0 outranks every other flag.
- R4: Bit b of status word k is flag index k*32+b; word 0 covers indices 0-31 and word 1 covers indices 32-63.
- R5: A read of offset 0 returns (base + (index << shift)) mod 2^32, for every shift value from 0 to 7.
- R6: A write to offset 1 stores only write-data bits [2:0] as the shift; a read of offset 1 returns the shift in bits [2:0] and zeros in bits [31:3].
- R7: Read data and the valid strobe appear one cycle after the read request. The value uses the flags and registers as they stand at the request edge, so a write to the same register in that same cycle is not visible to that read.
- R8: Offsets 2 and 3 are unmapped: reads return 0, and writes change neither the base nor the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| stat_word | input | 2x32 | Ready-flag status words, word 1 holds the higher indices |

## Verification
A write and a read can hit the same register in the same cycle, and a flag can change in the cycle a read is taken. The bench provokes both. It asserts bus_wr and bus_rd together on offset 0 and on offset 1, and it changes stat_word in the same cycle it issues a read. It then judges the returned data against a model that uses the state from before the write and the flags present at the sampling edge. A later plain read then shows that the write did land.

// File: rtl/vg_vecaddr_pkg.sv
package vg_vecaddr_pkg;

   localparam int unsigned REG_OFS_BASE = 0;
   localparam int unsigned REG_OFS_CTRL = 1;

   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_NONE = 2'd2
   } vg_rsel_e;

endpackage

// File: rtl/vg_prio_enc.sv
module vg_prio_enc #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (N < 1) begin : g_bad_n
      $error("vg_prio_enc: N must be at least 1");
   end
   if ((1 << IDX_W) < N) begin : g_bad_w
      $error("vg_prio_enc: IDX_W too narrow for N");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = i[IDX_W-1:0];
      end
      any = |req;
   end

endmodule

// File: rtl/vg_regfile.sv
module vg_regfile #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SHIFT_W = 3,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  base_q,
   output logic [SHIFT_W-1:0] shift_q
);
   import vg_vecaddr_pkg::*;

   if (SHIFT_W > DATA_W) begin : g_bad_shift
      $error("vg_regfile: SHIFT_W exceeds DATA_W");
   end

   logic hit_base;
   logic hit_ctrl;

   always_comb begin
      hit_base = wr_en && (wr_addr == ADDR_W'(REG_OFS_BASE));
      hit_ctrl = wr_en && (wr_addr == ADDR_W'(REG_OFS_CTRL));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         shift_q <= '0;
      end else begin
         if (hit_base) base_q  <= wr_data;
         if (hit_ctrl) shift_q <= wr_data[SHIFT_W-1:0];
      end
   end

endmodule

// File: rtl/vg_addr_calc.sv
module vg_addr_calc #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned SHIFT_W = 3
) (
   input  logic [DATA_W-1:0]  base,
   input  logic [IDX_W-1:0]   idx,
   input  logic               any,
   input  logic [SHIFT_W-1:0] shift,
   output logic [DATA_W-1:0]  vec_addr
);

   localparam int unsigned MAX_SHIFT = (1 << SHIFT_W) - 1;

   if (IDX_W + MAX_SHIFT > 2 * DATA_W) begin : g_bad_span
      $error("vg_addr_calc: shifted index far wider than data path");
   end

   logic [DATA_W-1:0] idx_ext;
   logic [DATA_W-1:0] offset;

   always_comb begin
      idx_ext  = any ? DATA_W'(idx) : '0;
      offset   = idx_ext << shift;
      vec_addr = base + offset;
   end

endmodule

// File: rtl/vg_vecaddr_top.sv
module vg_vecaddr_top #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned SHIFT_W   = 3,
   parameter int unsigned ADDR_W    = 2,
   parameter bit          SPLIT_ENC = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_wr,
   input  logic [DATA_W-1:0]                 bus_wdata,
   input  logic                              bus_rd,
   output logic [DATA_W-1:0]                 bus_rdata,
   output logic                              bus_rvalid,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  stat_word
);
   import vg_vecaddr_pkg::*;

   localparam int unsigned FLAG_N  = NUM_WORDS * WORD_W;
   localparam int unsigned IDX_W   = (FLAG_N > 1) ? $clog2(FLAG_N) : 1;
   localparam int unsigned WIDX_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam int unsigned WSEL_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   if (NUM_WORDS < 1 || WORD_W < 1) begin : g_bad_geom
      $error("vg_vecaddr_top: empty flag space");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("vg_vecaddr_top: ADDR_W must cover two registers");
   end
   if (SHIFT_W < 1 || SHIFT_W > DATA_W) begin : g_bad_shift
      $error("vg_vecaddr_top: SHIFT_W out of range");
   end

   logic [DATA_W-1:0]  base_q;
   logic [SHIFT_W-1:0] shift_q;
   logic               win_any;
   logic [IDX_W-1:0]   win_idx;
   logic [DATA_W-1:0]  vec_addr;

   vg_regfile #(
      .DATA_W  (DATA_W),
      .SHIFT_W (SHIFT_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .wr_addr (bus_addr),
      .wr_data (bus_wdata),
      .base_q  (base_q),
      .shift_q (shift_q)
   );

   if (SPLIT_ENC && NUM_WORDS > 1) begin : g_split
      logic [NUM_WORDS-1:0]             w_any;
      logic [NUM_WORDS-1:0][WIDX_W-1:0] w_idx;

      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
         vg_prio_enc #(
            .N     (WORD_W),
            .IDX_W (WIDX_W)
         ) u_enc (
            .req (stat_word[k]),
            .any (w_any[k]),
            .idx (w_idx[k])
         );
      end

      logic [WSEL_W-1:0] wsel;
      always_comb begin
         wsel = '0;
         for (int k = NUM_WORDS - 1; k >= 0; k--) begin
            if (w_any[k]) wsel = k[WSEL_W-1:0];
         end
         win_any = |w_any;
         win_idx = IDX_W'(wsel) * IDX_W'(WORD_W) + IDX_W'(w_idx[wsel]);
      end
   end else begin : g_flat
      vg_prio_enc #(
         .N     (FLAG_N),
         .IDX_W (IDX_W)
      ) u_enc (
         .req (stat_word),
         .any (win_any),
         .idx (win_idx)
      );
   end

   vg_addr_calc #(
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .SHIFT_W (SHIFT_W)
   ) u_calc (
      .base     (base_q),
      .idx      (win_idx),
      .any      (win_any),
      .shift    (shift_q),
      .vec_addr (vec_addr)
   );

   vg_rsel_e          rsel;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      if (bus_addr == ADDR_W'(REG_OFS_BASE))      rsel = SEL_BASE;
      else if (bus_addr == ADDR_W'(REG_OFS_CTRL)) rsel = SEL_CTRL;
      else                                        rsel = SEL_NONE;

      unique case (rsel)
         SEL_BASE: rd_mux = vec_addr;
         SEL_CTRL: rd_mux = DATA_W'(shift_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/vg_vecaddr_chk.sv
module vg_vecaddr_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned SHIFT_W   = 3,
   parameter int unsigned ADDR_W    = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [ADDR_W-1:0]                bus_addr,
   input logic                             bus_rd,
   input logic [DATA_W-1:0]                bus_rdata,
   input logic                             bus_rvalid,
   input logic [NUM_WORDS-1:0][WORD_W-1:0] stat_word,
   input logic [DATA_W-1:0]                base_q,
   input logic [SHIFT_W-1:0]               shift_q
);

   logic rd_base;
   logic rd_ctrl;
   logic rd_none;
   assign rd_base = bus_rd && (bus_addr == ADDR_W'(0));
   assign rd_ctrl = bus_rd && (bus_addr == ADDR_W'(1));
   assign rd_none = bus_rd && (bus_addr > ADDR_W'(1));

   // R7: valid strobe follows a read request by one cycle
   assert_rvalid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);
   assert_rvalid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);

   // R2: no flag set returns the stored base
   assert_base_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_base && (stat_word == '0)) |=> (bus_rdata == $past(base_q)));

   // R3: flag 0 set means index zero, so the base comes back unchanged
   assert_flag0_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_base && stat_word[0][0]) |=> (bus_rdata == $past(base_q)));

   // R5: the added offset has zeros below the shift position
   assert_offset_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_base |=> (((bus_rdata - $past(base_q)) &
                    ~({DATA_W{1'b1}} << $past(shift_q))) == '0));

   // R6: control read carries only the shift field
   assert_ctrl_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctrl |=> (bus_rdata == DATA_W'($past(shift_q))));

   // R8: unmapped offsets read as zero
   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_none |=> (bus_rdata == '0));

endmodule

bind vg_vecaddr_top vg_vecaddr_chk #(
   .DATA_W    (DATA_W),
   .WORD_W    (WORD_W),
   .NUM_WORDS (NUM_WORDS),
   .SHIFT_W   (SHIFT_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .stat_word  (stat_word),
   .base_q     (base_q),
   .shift_q    (shift_q)
);

// File: tb/tb_vg_vecaddr_top.sv
`timescale 1ns/1ps
module tb_vg_vecaddr_top;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [1:0]           bus_addr = '0;
   logic                 bus_wr = 1'b0;
   logic [31:0]          bus_wdata = '0;
   logic                 bus_rd = 1'b0;
   logic [31:0]          bus_rdata;
   logic                 bus_rvalid;
   logic [1:0][31:0]     stat_word = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] m_base  = '0;
   logic [2:0]  m_shift = '0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   vg_vecaddr_top dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .stat_word  (stat_word)
   );

   function automatic logic [31:0] model_vec(logic [31:0] b, logic [2:0] s,
                                             logic [63:0] flags);
      logic [31:0] ix;
      ix = 32'd0;
      for (int i = 0; i < 64; i++) begin
         if (flags[i]) begin
            ix = i;
            break;
         end
      end
      return b + (ix << s);
   endfunction

   function automatic logic [31:0] model_read(logic [1:0] a);
      case (a)
         2'd0:    return model_vec(m_base, m_shift, {stat_word[1], stat_word[0]});
         2'd1:    return {29'd0, m_shift};
         default: return 32'd0;
      endcase
   endfunction

   // driver: one bus cycle, optional write and read on the same offset
   task automatic bus_cycle(input logic [1:0] a, input bit do_wr,
                            input logic [31:0] wd, input bit do_rd,
                            input string tag);
      @(negedge clk);
      bus_addr  = a;
      bus_wr    = do_wr;
      bus_wdata = wd;
      bus_rd    = do_rd;
      if (do_rd) begin
         exp_q.push_back(model_read(a));
         tag_q.push_back(tag);
      end
      if (do_wr) begin
         if (a == 2'd0) m_base = wd;
         else if (a == 2'd1) m_shift = wd[2:0];
      end
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_cycle(a, 1'b1, d, 1'b0, "");
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      bus_cycle(a, 1'b0, '0, 1'b1, tag);
   endtask

   task automatic set_flags(input logic [31:0] lo, input logic [31:0] hi);
      @(negedge clk);
      stat_word[0] = lo;
      stat_word[1] = hi;
   endtask

   // monitor: pops expected values as read data comes out
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected read valid: actual %h expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      n_tests++;
      if (bus_rvalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 rvalid after reset: actual %b expected 0", bus_rvalid);
      end
      rd(2'd0, "R1 base after reset");
      rd(2'd1, "R1 ctrl after reset");

      // R2 full-width base, no flags
      wr(2'd0, 32'hA5A5_1234);
      rd(2'd0, "R2 base passthrough");
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, "R2 all-ones base");

      // R5 single flag, shift 0
      wr(2'd0, 32'h0000_1000);
      set_flags(32'h0000_0020, 32'h0);
      rd(2'd0, "R5 lo bit 5 shift 0");

      // R3 several flags, lowest wins
      set_flags(32'h0010_0080, 32'h0000_0008);
      rd(2'd0, "R3 lowest of several");
      set_flags(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(2'd0, "R3 flag 0 outranks all");

      // R4 upper word indexing
      wr(2'd1, 32'd4);
      set_flags(32'h0, 32'h0000_0008);
      rd(2'd0, "R4 hi bit 3 is index 35");
      set_flags(32'h0, 32'h8000_0000);
      rd(2'd0, "R4 hi bit 31 is index 63");
      set_flags(32'h8000_0000, 32'h0000_0001);
      rd(2'd0, "R4 lo bit 31 beats hi bit 0");

      // R5 every shift, fixed flag
      set_flags(32'h0, 32'h0000_0040);
      for (int s = 0; s < 8; s++) begin
         wr(2'd1, 32'(s));
         rd(2'd0, "R5 shift sweep");
      end

      // R5 wrap modulo 2^32
      wr(2'd0, 32'hFFFF_FF00);
      wr(2'd1, 32'd7);
      set_flags(32'h0, 32'h8000_0000);
      rd(2'd0, "R5 wraparound");
      n_tests++;
      if (model_vec(32'hFFFF_FF00, 3'd7, 64'h8000_0000_0000_0000) !== 32'h0000_1E80) begin
         n_fail++;
         $display("FAIL R5 model self-check: actual %h expected 00001e80",
                  model_vec(32'hFFFF_FF00, 3'd7, 64'h8000_0000_0000_0000));
      end

      // R6 only low three bits kept
      wr(2'd1, 32'hFFFF_FFFA);
      rd(2'd1, "R6 shift field masked");

      // R7 write and read same register, same cycle
      bus_cycle(2'd0, 1'b1, 32'h1234_0000, 1'b1, "R7 read before base write");
      rd(2'd0, "R7 base write landed");
      bus_cycle(2'd1, 1'b1, 32'd5, 1'b1, "R7 read before ctrl write");
      rd(2'd1, "R7 ctrl write landed");

      // R7 flags change at the read cycle
      @(negedge clk);
      stat_word[0] = 32'h0000_0004;
      stat_word[1] = 32'h0;
      bus_addr = 2'd0;
      bus_rd   = 1'b1;
      exp_q.push_back(model_read(2'd0));
      tag_q.push_back("R7 flags taken at request edge");
      @(negedge clk);
      bus_rd = 1'b0;

      // R8 unmapped offsets
      rd(2'd2, "R8 offset 2 reads zero");
      rd(2'd3, "R8 offset 3 reads zero");
      bus_cycle(2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, "");
      bus_cycle(2'd3, 1'b1, 32'hCAFE_F00D, 1'b0, "");
      set_flags(32'h0, 32'h0);
      rd(2'd0, "R8 base untouched by unmapped write");
      rd(2'd1, "R8 shift untouched by unmapped write");

      repeat (4) @(negedge clk);
      n_tests++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R7 missing read responses: actual %0d pending expected 0",
                  exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule